// File: doc/BRIEF.md
# Three-Lane 7:1 Serial Frame Deserializer

This block turns three serial data lanes into one 21-bit parallel word per frame. It runs on a bit clock at seven times the frame rate and takes one pre-sampled bit per lane on each bit-clock edge. A fourth input carries the frame clock, sampled in the same bit-clock domain. Over a frame that clock is high for four bit times and then low for three. Its low-to-high transition marks the first bit of a frame.

Within each lane the most significant bit arrives first. The block checks the clock-lane pattern on every cycle and reports a frame clock as valid only after two clean frames in a row. It then delivers each word one frame after that word's last bit was sampled. A frame-rate output clock goes with the word; downstream logic captures on its falling edge. An active-low shutdown input, and a frame clock that is missing or broken, both force the outputs low.

Top module: `lane_deser7`

## Requirements
- R1: Lane 0 fills word bits 6..0, lane 1 fills bits 13..7 and lane 2 fills bits 20..14, with the lowest index of each slice as its LSB.
- R2: In every lane the first bit of a frame (sampled on the edge where the clock lane first reads 1) is the MSB of that lane's slice and the seventh bit is its LSB.
- R3: All 21 output bits change together once per frame, on the bit-clock edge that samples the last bit of the following frame, so a word appears one frame after its own last bit was sampled and stays constant for seven cycles.
- R4: While locked, the output clock rises on the edge that updates the word, stays high for 4 bit-clock cycles and low for 3.
- R5: From reset, lock is declared on the last edge of the second consecutive frame whose clock lane reads 1111000 in bit order. On that edge the output clock starts with the word still zero, and the first nonzero-capable word output is the second good frame, delivered one frame later.
- R6: A clock-lane sample that breaks the 1111000 pattern (including a rising transition at the wrong phase) drops lock on that edge: the word goes to zero and the output clock to low. Two new good frames are then needed before data flows again.
- R7: A missing frame clock (clock lane held low) keeps the word at zero and the output clock low, whatever the data lanes carry.
- R8: While the active-low shutdown input is sampled low, every register is cleared. From the next edge the word is zero and the output clock low, and after release the block must relock as in R5.
- R9: After the asynchronous reset the word is zero and the output clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown, synchronous clear of all state |
| lane_in | input | 3 | Sampled data bit of each lane, index = lane |
| fclk_in | input | 1 | Sampled frame-clock lane |
| word_out | output | 21 | Deserialized parallel word |
| word_clk_out | output | 1 | Frame-rate output clock, data stable at its falling edge |

## Verification
The assertions rely on the lane samples being synchronous to the bit clock, one sample per lane per edge. They also rely on shutdown being a level sampled on that clock and not an asynchronous pulse. The stuck-lane property assumes that five equal consecutive clock-lane samples can never belong to a valid frame; this holds for the 4-high/3-low shape. The stimulus drives every input on the falling edge. It only uses clock-lane patterns that are the exact frame shape, all zeros, or a frame that goes low one bit early. It pulses shutdown for two bit times inside a frame, so the relock count after each disturbance is known ahead of time.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int unsigned BITS_PER_LANE = 7;
  localparam int unsigned HIGH_BITS     = 4;
  localparam int unsigned NUM_LANES     = 3;
  localparam int unsigned LOCK_FRAMES   = 2;
  localparam int unsigned WORD_BITS     = NUM_LANES * BITS_PER_LANE;
endpackage

// File: rtl/frame_tracker.sv
module frame_tracker #(
  parameter int unsigned BITS   = 7,
  parameter int unsigned HIGH   = 4,
  parameter int unsigned NLOCK  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fclk,
  output logic frame_done,
  output logic lock_next,
  output logic phase_hi
);
  localparam int unsigned POS_W = $clog2(BITS + 1);
  localparam int unsigned CNT_W = $clog2(NLOCK + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BITS - 1);
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(BITS);
  localparam logic [POS_W-1:0] POS_HIGH = POS_W'(HIGH);
  localparam logic [CNT_W-1:0] CNT_LOCK = CNT_W'(NLOCK);

  logic             prev_q, prev_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic             ok_q, ok_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rise, bad;

  always_comb begin
    rise   = fclk & ~prev_q;
    prev_n = fclk;
    if (rise) begin
      pos_n = '0;
      bad   = (pos_q != POS_LAST);
    end else begin
      pos_n = (pos_q == POS_IDLE) ? POS_IDLE : pos_q + 1'b1;
      bad   = (pos_n == POS_IDLE) || (fclk != (pos_n < POS_HIGH));
    end
    ok_n       = rise ? 1'b1 : (bad ? 1'b0 : ok_q);
    frame_done = ok_n && (pos_n == POS_LAST);
    if (bad)
      cnt_n = '0;
    else if (frame_done && (cnt_q < CNT_LOCK))
      cnt_n = cnt_q + 1'b1;
    else
      cnt_n = cnt_q;
    lock_next = (cnt_n >= CNT_LOCK);
    phase_hi  = (pos_n == POS_LAST) || (pos_n < POS_HIGH - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pos_q  <= POS_IDLE;
      ok_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (clr) begin
      prev_q <= 1'b0;
      pos_q  <= POS_IDLE;
      ok_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_n;
      pos_q  <= pos_n;
      ok_q   <= ok_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int unsigned BITS = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            din,
  output logic [BITS-1:0] shift_next
);
  logic [BITS-1:0] sh_q;

  always_comb shift_next = {sh_q[BITS-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh_q <= '0;
    else if (clr) sh_q <= '0;
    else          sh_q <= shift_next;
  end
endmodule

// File: rtl/word_stage.sv
module word_stage #(
  parameter int unsigned WIDTH = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             frame_done,
  input  logic             lock_next,
  input  logic             phase_hi,
  input  logic [WIDTH-1:0] new_word,
  output logic [WIDTH-1:0] word,
  output logic             wclk
);
  logic [WIDTH-1:0] cap_q, cap_n, word_n;
  logic             cap_ok_q, cap_ok_n, wclk_n;

  always_comb begin
    cap_n    = cap_q;
    cap_ok_n = cap_ok_q;
    word_n   = word;
    if (!lock_next) begin
      word_n   = '0;
      cap_ok_n = 1'b0;
    end else if (frame_done) begin
      word_n   = cap_ok_q ? cap_q : '0;
      cap_n    = new_word;
      cap_ok_n = 1'b1;
    end
    wclk_n = lock_next & phase_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= '0;
      cap_ok_q <= 1'b0;
      word     <= '0;
      wclk     <= 1'b0;
    end else if (clr) begin
      cap_q    <= '0;
      cap_ok_q <= 1'b0;
      word     <= '0;
      wclk     <= 1'b0;
    end else begin
      cap_q    <= cap_n;
      cap_ok_q <= cap_ok_n;
      word     <= word_n;
      wclk     <= wclk_n;
    end
  end
endmodule

// File: rtl/lane_deser7.sv
module lane_deser7
  import deser_pkg::*;
#(
  parameter int unsigned BITS   = BITS_PER_LANE,
  parameter int unsigned HIGH   = HIGH_BITS,
  parameter int unsigned LANES  = NUM_LANES,
  parameter int unsigned NLOCK  = LOCK_FRAMES,
  localparam int unsigned WIDTH = LANES * BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_n,
  input  logic [LANES-1:0] lane_in,
  input  logic             fclk_in,
  output logic [WIDTH-1:0] word_out,
  output logic             word_clk_out
);
  logic             clr;
  logic             frame_done, lock_next, phase_hi;
  logic [WIDTH-1:0] new_word;

  assign clr = ~shdn_n;

  frame_tracker #(.BITS(BITS), .HIGH(HIGH), .NLOCK(NLOCK)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fclk(fclk_in),
    .frame_done(frame_done), .lock_next(lock_next), .phase_hi(phase_hi)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_shifter #(.BITS(BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(clr), .din(lane_in[g]),
      .shift_next(new_word[g*BITS +: BITS])
    );
  end

  word_stage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .frame_done(frame_done), .lock_next(lock_next), .phase_hi(phase_hi),
    .new_word(new_word), .word(word_out), .wclk(word_clk_out)
  );
endmodule

// File: rtl/lane_deser7_chk.sv
module lane_deser7_chk #(
  parameter int unsigned WIDTH = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shdn_n,
  input logic             fclk_in,
  input logic [WIDTH-1:0] word_out,
  input logic             word_clk_out
);
  logic       seen_q;
  logic       last_q;
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= 1'b0;
      run_q  <= '0;
    end else begin
      seen_q <= 1'b1;
      last_q <= fclk_in;
      if (!shdn_n)
        run_q <= '0;
      else if (fclk_in == last_q && seen_q)
        run_q <= (run_q == 3'd7) ? run_q : run_q + 3'd1;
      else
        run_q <= 3'd1;
    end
  end

  AST_SHDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (word_out == '0) && !word_clk_out); // R8

  AST_WORD_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$stable(word_out)) |-> ($rose(word_clk_out) || word_out == '0)); // R3

  AST_WCLK_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $rose(word_clk_out) && shdn_n) |=> (word_clk_out || word_out == '0)); // R4

  AST_STUCK_LANE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q >= 3'd5) |-> (word_out == '0) && !word_clk_out); // R7

  AST_RESET_LOW: assert property (@(posedge clk)
    !seen_q |-> (word_out == '0) && !word_clk_out); // R9
endmodule

bind lane_deser7 lane_deser7_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .fclk_in(fclk_in),
  .word_out(word_out), .word_clk_out(word_clk_out)
);

// File: tb/lane_deser7_test.sv
module lane_deser7_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] GOOD = 7'b1111000;
  localparam logic [6:0] NONE = 7'b0000000;
  localparam logic [6:0] SHORT = 7'b1110000;

  logic        clk;
  logic        rst_n;
  logic        shdn_n;
  logic [2:0]  lane_in;
  logic        fclk_in;
  logic [20:0] word_out;
  logic        word_clk_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int          gs;
  logic [20:0] w1, w2;

  lane_deser7 uut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .lane_in(lane_in),
    .fclk_in(fclk_in), .word_out(word_out), .word_clk_out(word_clk_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame of 7 bits; clock-lane pattern given MSB first; shutdown low on bits sd and sd+1
  task automatic send_frame(input logic [20:0] w, input logic [6:0] cpat,
                            input bit chk, input int sd, input string ztag);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (chk) begin
        if (i == 0) begin
          if (gs >= 3) check("R1 R2 R3 word", word_out, w2);
          else         check({ztag, " word held zero"}, word_out, '0);
        end
        if (i == 4) check("R3 word stable mid-frame", word_out, (gs >= 3) ? w2 : 21'h0);
        if (gs == 2 && i == 0) check("R5 output clock starts at lock", {20'h0, word_clk_out}, 21'h1);
        else check("R4 output clock shape", {20'h0, word_clk_out}, {20'h0, (gs >= 2) && (i < 4)});
      end
      if (sd >= 0 && i == sd + 1)
        check("R8 outputs low in shutdown", {word_out[19:0], word_clk_out}, '0);
      lane_in[0] = w[6 - i];
      lane_in[1] = w[13 - i];
      lane_in[2] = w[20 - i];
      fclk_in    = cpat[6 - i];
      shdn_n     = !(sd >= 0 && (i == sd || i == sd + 1));
    end
    w2 = w1;
    w1 = w;
    if (cpat == GOOD && sd < 0) gs++;
    else gs = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; shdn_n = 1'b1; lane_in = '0; fclk_in = 1'b0;
    gs = 0; w1 = '0; w2 = '0;
    repeat (3) @(negedge clk);
    check("R9 reset word", word_out, '0);
    check("R9 reset clock", {20'h0, word_clk_out}, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_lock_and_data();
    send_frame(21'h1FFFFF, GOOD, 1, -1, "R5");
    send_frame(21'h0A5C3E, GOOD, 1, -1, "R5");
    send_frame(21'h155555, GOOD, 1, -1, "R5");
    for (int k = 0; k < 21; k++) send_frame(21'h1 << k, GOOD, 1, -1, "R5");
    for (int k = 0; k < 12; k++) send_frame(21'($urandom()), GOOD, 1, -1, "R5");
    send_frame(21'h000000, GOOD, 1, -1, "R5");
    send_frame(21'h0AAAAA, GOOD, 1, -1, "R5");
  endtask

  task automatic t_corrupt();
    send_frame(21'h12345, SHORT, 1, -1, "R6");
    for (int k = 0; k < 5; k++) send_frame(21'($urandom()), GOOD, 1, -1, "R6");
  endtask

  task automatic t_missing();
    for (int k = 0; k < 3; k++) send_frame(21'h1FFFFF, NONE, 0, -1, "R7");
    for (int k = 0; k < 2; k++) send_frame(21'h1FFFFF, GOOD, 1, -1, "R7");
    for (int k = 0; k < 3; k++) send_frame(21'($urandom()), GOOD, 1, -1, "R7");
  endtask

  task automatic t_shutdown();
    send_frame(21'h1F0F0F, GOOD, 0, 2, "R8");
    for (int k = 0; k < 5; k++) send_frame(21'($urandom()), GOOD, 1, -1, "R8");
  endtask

  initial begin
    t_reset();
    t_lock_and_data();
    t_corrupt();
    t_missing();
    t_shutdown();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule